// File: doc/BRIEF.md
# Grouped priority interrupt controller

This block collects eighteen interrupt request lines, remembers each new request until the CPU has taken it, and offers the CPU one vector at a time. The sources are arranged in six groups of three. Each group carries a two-bit priority level, and all three members of a group share it. Every source also has its own enable bit, and one global enable gates what is offered to the CPU.

The CPU takes the offered vector with a one-cycle acknowledge. That clears the source's pending bit and records the vector's level as the active handler level. A handler can be interrupted only by a request of strictly higher level, so active levels nest up to four deep. An end-of-interrupt pulse returns to the previous level.

Separately from the CPU path, a fixed subset of sources raises a wake request while the system is asleep.

Top module: `irq_grouped_ctrl`

## Requirements
- R1: While reset is held, `irq_valid_o` and `wake_o` are 0, and no request seen during reset becomes pending.
- R2: A source becomes pending one clock after a 0-to-1 change on its `req_i` bit. A request line that stays high does not set the bit again after it has been cleared.
- R3: `irq_ack_i` clears the pending bit of the offered source and pushes its level only when `irq_valid_o` is 1. An acknowledge given while `irq_valid_o` is 0 changes nothing.
- R4: Source index s belongs to group s mod 6 as member s div 6, and `irq_vec_o` carries s. Within one group, the lower member index wins.
- R5: Group g takes its level from `grp_level_i[2g+1:2g]`, and 3 is the highest level. A pending source in a group of higher level wins. Between groups of equal level, the lower group index wins.
- R6: A source whose `src_en_i` bit is 0 is never offered and does not hide other sources. Its pending bit is still latched, so setting the enable later offers it.
- R7: With `glb_en_i` at 0, `irq_valid_o` is 0. Pending bits still latch and `wake_o` still works.
- R8: While handlers are active, a request is offered only if its level is strictly above the most recent active level. Equal and lower levels wait. The stack holds up to four levels.
- R9: `irq_eoi_i` removes the most recent active level. It is ignored in a cycle that also accepts an acknowledge, and it is ignored when no handler is active.
- R10: `wake_o` is 1 exactly when `sleep_i` is 1 and some source that is pending, individually enabled and inside the wake set (parameter, default sources 0, 1 and 2) exists.
- R11: `irq_level_o` gives the level of the group of the offered source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 18 | Request lines, one per source |
| src_en_i | input | 18 | Per-source enable |
| glb_en_i | input | 1 | Global enable of the CPU offer |
| grp_level_i | input | 12 | Two-bit level per group, group g at bits 2g+1:2g |
| sleep_i | input | 1 | System is in a sleep mode |
| irq_ack_i | input | 1 | CPU takes the offered vector |
| irq_eoi_i | input | 1 | CPU ends the current handler |
| irq_valid_o | output | 1 | A vector is offered |
| irq_vec_o | output | 5 | Index of the offered source |
| irq_level_o | output | 2 | Level of the offered source |
| wake_o | output | 1 | Wake request while asleep |

## Verification
A pending bit that sticks or is lost shows up in the cycle after the edge or acknowledge: either a vector stays offered after it was taken, or a source never appears. A fault in the resolver shows up immediately as a wrong `irq_vec_o` or `irq_level_o` when two sources compete. That is why every ordered pair of sources is swept under changing group levels. A corrupted nesting stack stays hidden until a later request of equal or lower level is offered too early or held too long. The bench therefore fills the stack, pops it one level at a time, and probes the blocking after each pop.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NGRP  = 6;
  localparam int unsigned GSZ   = 3;
  localparam int unsigned NSRC  = NGRP * GSZ;
  localparam int unsigned LVL_W = 2;
  localparam int unsigned NEST  = 4;
  localparam int unsigned VEC_W = $clog2(NSRC);
  localparam int unsigned MEM_W = $clog2(GSZ);
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int unsigned N = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q, pend_q, pend_d, rise;
  logic         upd_en;

  assign rise = req_i & ~req_q;

  always_comb begin
    upd_en = |(rise | clr_i);
    pend_d = (pend_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q <= req_i;
      if (upd_en) pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R2: a rising edge leaves the bit pending in the next cycle
  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R3: a clear without a coincident edge empties the bit
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~rise)) |=> ((pend_q & $past(clr_i & ~rise)) == '0));
endmodule

// File: rtl/irq_group_pick.sv
module irq_group_pick #(
  parameter int unsigned GSZ = 3,
  parameter int unsigned MW  = 2
) (
  input  logic [GSZ-1:0] live_i,
  output logic           hit_o,
  output logic [MW-1:0]  mem_o
);
  always_comb begin
    hit_o = 1'b0;
    mem_o = '0;
    for (int m = GSZ - 1; m >= 0; m--) begin
      if (live_i[m]) begin
        hit_o = 1'b1;
        mem_o = MW'(m);
      end
    end
  end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
  parameter int unsigned NG    = 6,
  parameter int unsigned MW    = 2,
  parameter int unsigned LW    = 2,
  parameter int unsigned VW    = 5
) (
  input  logic [NG-1:0]    hit_i,
  input  logic [NG*MW-1:0] mem_i,
  input  logic [NG*LW-1:0] lvl_i,
  output logic             found_o,
  output logic [LW-1:0]    lvl_o,
  output logic [VW-1:0]    vec_o
);
  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    vec_o   = '0;
    for (int g = 0; g < NG; g++) begin
      if (hit_i[g] && (!found_o || (lvl_i[g*LW +: LW] > lvl_o))) begin
        found_o = 1'b1;
        lvl_o   = lvl_i[g*LW +: LW];
        vec_o   = VW'(g + NG * int'(mem_i[g*MW +: MW]));
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [LW-1:0] lvl_i,
  output logic          empty_o,
  output logic [LW-1:0] top_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [LW-1:0] lvl_q [DEPTH];
  logic [LW-1:0] lvl_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d, cnt_m1;
  logic          do_pop, cnt_en;

  assign cnt_m1 = cnt_q - CW'(1);
  assign do_pop = pop_i && !push_i && (cnt_q != '0);

  always_comb begin
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    cnt_en = push_i || do_pop;
    if (push_i) begin
      lvl_d[cnt_q[IW-1:0]] = lvl_i;
      cnt_d = cnt_q + CW'(1);
    end else if (do_pop) begin
      cnt_d = cnt_m1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign empty_o = (cnt_q == '0);
  assign top_o   = lvl_q[cnt_m1[IW-1:0]];

  // R8: never pushed beyond the stack depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < CW'(DEPTH)));

  // R8: each nested level lies strictly above the one below it
  a_r8_rising_push: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && cnt_q != '0) |-> (lvl_i > top_o));

  // R9: a lone end-of-interrupt removes exactly one level
  a_r9_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/irq_grouped_ctrl.sv
module irq_grouped_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_GRP    = NGRP,
  parameter int unsigned GRP_SZ     = GSZ,
  parameter int unsigned LVL_BITS   = LVL_W,
  parameter int unsigned NEST_DEPTH = NEST,
  parameter logic [NUM_GRP*GRP_SZ-1:0] WAKE_SRC_MASK = (NUM_GRP*GRP_SZ)'(7)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_GRP*GRP_SZ-1:0]           req_i,
  input  logic [NUM_GRP*GRP_SZ-1:0]           src_en_i,
  input  logic                                glb_en_i,
  input  logic [NUM_GRP*LVL_BITS-1:0]         grp_level_i,
  input  logic                                sleep_i,
  input  logic                                irq_ack_i,
  input  logic                                irq_eoi_i,
  output logic                                irq_valid_o,
  output logic [$clog2(NUM_GRP*GRP_SZ)-1:0]   irq_vec_o,
  output logic [LVL_BITS-1:0]                 irq_level_o,
  output logic                                wake_o
);
  localparam int unsigned NS = NUM_GRP * GRP_SZ;
  localparam int unsigned VW = $clog2(NS);
  localparam int unsigned MW = $clog2(GRP_SZ);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NS-1:0]         pend, live, clr;
  logic [NUM_GRP-1:0]    grp_hit;
  logic [NUM_GRP*MW-1:0] grp_mem;
  logic                  found, stk_empty, push, pop;
  logic [LVL_BITS-1:0]   best_lvl, stk_top;
  logic [VW-1:0]         best_vec;

  irq_edge_latch #(.N(NS)) u_latch (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .req_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign live = pend & src_en_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [GRP_SZ-1:0] live_g;
    for (genvar m = 0; m < GRP_SZ; m++) begin : g_mem
      assign live_g[m] = live[g + NUM_GRP*m];
    end
    irq_group_pick #(.GSZ(GRP_SZ), .MW(MW)) u_pick (
      .live_i (live_g),
      .hit_o  (grp_hit[g]),
      .mem_o  (grp_mem[g*MW +: MW])
    );
  end

  irq_level_arb #(.NG(NUM_GRP), .MW(MW), .LW(LVL_BITS), .VW(VW)) u_arb (
    .hit_i   (grp_hit),
    .mem_i   (grp_mem),
    .lvl_i   (grp_level_i),
    .found_o (found),
    .lvl_o   (best_lvl),
    .vec_o   (best_vec)
  );

  irq_nest_stack #(.DEPTH(NEST_DEPTH), .LW(LVL_BITS)) u_stack (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push_i  (push),
    .pop_i   (pop),
    .lvl_i   (best_lvl),
    .empty_o (stk_empty),
    .top_o   (stk_top)
  );

  always_comb begin
    irq_valid_o = glb_en_i && found && (stk_empty || (best_lvl > stk_top));
    irq_vec_o   = best_vec;
    irq_level_o = best_lvl;
    push        = irq_ack_i && irq_valid_o;
    pop         = irq_eoi_i;
    clr         = push ? (NS'(1) << best_vec) : '0;
    wake_o      = sleep_i && (|(live & WAKE_SRC_MASK));
  end

  // R7: nothing is offered while the global enable is low
  a_r7_glb_gate: assert property (@(posedge clk) disable iff (!rst_int_n)
    !glb_en_i |-> !irq_valid_o);

  // R4: an offered index names a real source
  a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_valid_o |-> (int'(irq_vec_o) < NS));

  // R5: the offered source is pending and enabled
  a_r5_winner_live: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_valid_o |-> live[irq_vec_o]);

  // R10: no wake request outside sleep
  a_r10_wake_sleep: assert property (@(posedge clk) disable iff (!rst_int_n)
    wake_o |-> sleep_i);
endmodule

// File: tb/irq_grouped_ctrl_test.sv
module irq_grouped_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] req_i, src_en_i;
  logic        glb_en_i, sleep_i, irq_ack_i, irq_eoi_i;
  logic [11:0] grp_level_i;
  logic        irq_valid_o, wake_o;
  logic [4:0]  irq_vec_o;
  logic [1:0]  irq_level_o;

  int checks = 0;
  int errors = 0;
  int lvl_tab [6];
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_grouped_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .src_en_i(src_en_i),
    .glb_en_i(glb_en_i), .grp_level_i(grp_level_i), .sleep_i(sleep_i),
    .irq_ack_i(irq_ack_i), .irq_eoi_i(irq_eoi_i), .irq_valid_o(irq_valid_o),
    .irq_vec_o(irq_vec_o), .irq_level_o(irq_level_o), .wake_o(wake_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input int exp);
    chk(irq_valid_o && int'(irq_vec_o) == exp, tag,
        irq_valid_o ? int'(irq_vec_o) : -1, exp);
  endtask

  task automatic chk_idle(input string tag);
    chk(!irq_valid_o, tag, int'(irq_valid_o), 0);
  endtask

  task automatic set_levels();
    for (int g = 0; g < 6; g++) grp_level_i[g*2 +: 2] = 2'(lvl_tab[g]);
  endtask

  task automatic serve();
    irq_ack_i = 1'b1; step(); irq_ack_i = 1'b0;
  endtask

  task automatic end_irq();
    irq_eoi_i = 1'b1; step(); irq_eoi_i = 1'b0;
  endtask

  function automatic int winner(input int a, input int b);
    int ga, gb;
    ga = a % 6; gb = b % 6;
    if (lvl_tab[ga] != lvl_tab[gb]) return (lvl_tab[ga] > lvl_tab[gb]) ? a : b;
    if (ga != gb) return (ga < gb) ? a : b;
    return (a / 6 < b / 6) ? a : b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_i = '0; src_en_i = '1; glb_en_i = 1'b1; sleep_i = 1'b1;
    irq_ack_i = 1'b0; irq_eoi_i = 1'b0; grp_level_i = '0;
    for (int g = 0; g < 6; g++) lvl_tab[g] = 0;
    step(); step();
    // R1: quiet during reset, even asleep with a wake-capable line raised
    req_i[0] = 1'b1;
    step();
    chk(!irq_valid_o, "R1 valid in reset", int'(irq_valid_o), 0);
    chk(!wake_o, "R1 wake in reset", int'(wake_o), 0);
    req_i = '0; sleep_i = 1'b0;
    step();
    rst_n = 1'b1;
    step(); step(); step();
    chk_idle("R1 nothing pending after reset");

    // R4 / R11: each source alone, group g at level g mod 4
    for (int g = 0; g < 6; g++) lvl_tab[g] = g % 4;
    set_levels();
    for (int s = 0; s < 18; s++) begin
      req_i = 18'(1) << s;
      step();
      chk_vec("R4 single source index", s);
      chk(int'(irq_level_o) == (s % 6) % 4, "R11 level of offer", int'(irq_level_o), (s % 6) % 4);
      serve(); end_irq();
      chk_idle("R3 acknowledged source cleared");
      req_i = '0;
      step();
    end

    // R5 / R4: every ordered pair under shifting levels
    for (int a = 0; a < 18; a++) begin
      for (int b = 0; b < 18; b++) begin
        if (a != b) begin
          for (int g = 0; g < 6; g++) lvl_tab[g] = (g * (a + 1) + b) % 4;
          set_levels();
          req_i = (18'(1) << a) | (18'(1) << b);
          step();
          chk_vec("R5 pair winner", winner(a, b));
          serve(); end_irq();
          chk_vec("R5 pair loser follows", (winner(a, b) == a) ? b : a);
          serve(); end_irq();
          req_i = '0;
          step();
        end
      end
    end

    for (int g = 0; g < 6; g++) lvl_tab[g] = 0;
    set_levels();

    // R2: a held line does not re-pend; a fresh edge does
    req_i[4] = 1'b1; step();
    chk_vec("R2 edge sets pending", 4);
    serve(); end_irq(); step();
    chk_idle("R2 held line no repend");
    req_i[4] = 1'b0; step();
    req_i[4] = 1'b1; step();
    chk_vec("R2 new edge pends again", 4);
    serve(); end_irq();
    req_i = '0; step();

    // R7 / R3: global enable off, ack ignored, wake unaffected
    glb_en_i = 1'b0; sleep_i = 1'b1;
    req_i[2] = 1'b1; step();
    chk_idle("R7 global enable blocks offer");
    chk(wake_o, "R7 wake with global enable off", int'(wake_o), 1);
    serve();
    sleep_i = 1'b0; glb_en_i = 1'b1; step();
    chk_vec("R3 ack without offer ignored", 2);
    serve(); end_irq();
    req_i = '0; step();

    // R6: disabled source latched, released when enabled, never hides others
    src_en_i[5] = 1'b0;
    req_i[5] = 1'b1; step();
    chk_idle("R6 disabled source not offered");
    src_en_i[5] = 1'b1; step();
    chk_vec("R6 enabling offers latched source", 5);
    serve(); end_irq();
    req_i = '0; step();
    lvl_tab[0] = 3; set_levels();
    src_en_i[0] = 1'b0;
    req_i[0] = 1'b1; req_i[1] = 1'b1; step();
    chk_vec("R6 disabled source does not hide", 1);
    serve(); end_irq();
    src_en_i[0] = 1'b1; step();
    chk_vec("R6 late enable of source 0", 0);
    serve(); end_irq();
    req_i = '0; step();

    // R8 / R9: nesting
    lvl_tab[0] = 1; lvl_tab[1] = 2; lvl_tab[2] = 1;
    lvl_tab[3] = 0; lvl_tab[4] = 3; lvl_tab[5] = 0;
    set_levels();
    req_i[3] = 1'b1; step();
    chk_vec("R8 first handler", 3);
    serve();
    req_i[0] = 1'b1; step();
    chk_vec("R8 higher level preempts", 0);
    serve();
    req_i[2] = 1'b1; step();
    chk_idle("R8 equal level waits");
    req_i[9] = 1'b1; step();
    chk_idle("R8 lower level waits");
    req_i[1] = 1'b1; step();
    chk_vec("R8 level 2 preempts", 1);
    serve();
    req_i[4] = 1'b1; step();
    chk_vec("R8 level 3 preempts", 4);
    serve();
    req_i[10] = 1'b1; step();
    chk_idle("R8 full stack blocks equal top");
    end_irq();
    chk_vec("R9 pop exposes level 3 request", 10);
    serve();
    end_irq(); end_irq();
    chk_idle("R9 level 1 still active");
    end_irq();
    chk_vec("R9 pop to level 0 offers level 1", 2);
    serve(); end_irq(); end_irq();
    chk_vec("R9 empty stack offers level 0", 9);
    serve(); end_irq();
    end_irq();
    chk_idle("R9 extra eoi harmless");
    req_i = '0; step();

    // R9: eoi together with ack is ignored
    req_i[5] = 1'b1; step();
    chk_vec("R9 source 5 offered", 5);
    irq_ack_i = 1'b1; irq_eoi_i = 1'b1; step();
    irq_ack_i = 1'b0; irq_eoi_i = 1'b0;
    req_i[11] = 1'b1; step();
    chk_idle("R9 eoi with ack ignored");
    end_irq();
    chk_vec("R9 pop after ack", 11);
    serve(); end_irq();
    end_irq(); end_irq();
    req_i = '0; step();
    req_i[17] = 1'b1; step();
    chk_vec("R9 after eoi on empty", 17);
    serve();
    req_i[5] = 1'b1; step();
    chk_idle("R9 no underflow left behind");
    end_irq();
    chk_vec("R9 single pop empties", 5);
    serve(); end_irq();
    req_i = '0; step();

    // R10: wake set
    sleep_i = 1'b1;
    req_i[3] = 1'b1; step();
    chk(!wake_o, "R10 source outside wake set", int'(wake_o), 0);
    req_i[0] = 1'b1; step();
    chk(wake_o, "R10 wake source asleep", int'(wake_o), 1);
    src_en_i[0] = 1'b0; #1;
    chk(!wake_o, "R10 disabled wake source", int'(wake_o), 0);
    src_en_i[0] = 1'b1; sleep_i = 1'b0; #1;
    chk(!wake_o, "R10 awake no wake", int'(wake_o), 0);
    step();
    repeat (4) begin
      if (irq_valid_o) serve();
      end_irq();
    end
    req_i = '0; step();
    chk_idle("R3 all drained");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule